// File: doc/BRIEF.md
# Five-Stage Pipeline Interlock Controller

This block decides, cycle by cycle, whether an in-order five-stage pipeline (fetch, decode, execute, memory, write-back) may advance. It holds a compact shift model of the instructions in the four stages after fetch. For each one it keeps a valid flag, a memory-access flag and a destination register, and for the decode stage it also keeps two source registers. From that model it raises the pipeline's hold and bubble controls. There are no forwarding paths. A consumer waits until its producer has reached write-back. Fetch is refused whenever a load or store occupies the memory stage, because that stage and fetch share one single-ported memory.

New instructions arrive as a valid/ready stream of descriptors, and a descriptor is accepted only on a cycle with both `in_valid` and `in_ready` high. While `in_valid` is high and `in_ready` is low, the source must hold the descriptor steady. The block never stores more than one descriptor per stage. When nothing is accepted, an empty slot enters decode.

The block also reports per-stage occupancy and pulses `retire` for each real instruction in write-back. A wrapping counter of retired instructions lets a bench measure the completion timing of a scripted sequence. Register 0 is never a dependency. A source or destination field of 0 means "none".

Top module: `pipe_interlock`

## Requirements
- R1: After reset every tracked stage is empty, all hold and bubble outputs are 0, `in_ready` is 1 and `retire_count` is 0.
- R2: With no stalls, a descriptor accepted in cycle c shows `retire`=1 in cycle c+4. Back-to-back accepted descriptors retire one per cycle.
- R3: While the memory stage holds a valid instruction with its memory-access flag set, `in_ready` is 0 and `pc_hold` is 1. Fetch resumes in the next cycle unless the following instruction also accesses memory.
- R4: When the decode instruction has a nonzero source equal to the destination of a valid instruction in execute or in memory, `id_hold`, `ex_nop` and `pc_hold` are 1. The decode instruction stays in place and execute receives an empty slot. A match against write-back never stalls.
- R5: A source or destination of register 0 never causes a stall.
- R6: `id_nop` is 1 exactly when the memory port is busy (R3) and no dependency stall (R4) is active. When both apply, `id_hold` is 1, `id_nop` is 0 and fetch stays refused.
- R7: `retire_count` increments by one, modulo 2^CNT_W, at the end of every cycle in which `retire` is 1.
- R8: A descriptor is taken only when `in_valid` and `in_ready` are both 1. `in_ready` does not depend on `in_valid`. A cycle with no accepted descriptor puts an empty slot into decode.
- R9: `stage_busy` bit 0 is 1 when a descriptor is accepted this cycle. Bits 1, 2, 3 and 4 show valid instructions in decode, execute, memory and write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | A fetch descriptor is offered |
| in_ready | output | 1 | Fetch may proceed this cycle |
| in_mem | input | 1 | Offered instruction is a load or store |
| in_dst | input | REG_W | Destination register, 0 for none |
| in_src_a | input | REG_W | First source register, 0 for none |
| in_src_b | input | REG_W | Second source register, 0 for none |
| pc_hold | output | 1 | Program counter must keep its value |
| id_hold | output | 1 | Fetch/decode register must keep its value |
| id_nop | output | 1 | An empty slot is placed into decode because fetch lost the memory port |
| ex_nop | output | 1 | An empty slot is placed into execute |
| stage_busy | output | 5 | Occupancy of fetch, decode, execute, memory and write-back, in bits 0 to 4 |
| retire | output | 1 | A real instruction is in write-back |
| retire_count | output | CNT_W | Wrapping count of retired instructions |

## Verification
The bench builds the block with REG_W=3 and CNT_W=4. With only eight register names, randomly drawn sources and destinations collide often, so dependency stalls from both execute and memory, and their overlap with memory-port stalls, occur many times in a short run. The 4-bit counter wraps every sixteen retirements, so the modulo behaviour of the retire count is checked repeatedly. Directed sequences then measure exact retirement cycles for independent, dependent, memory-bound and register-0 cases.

// File: rtl/pic_pkg.sv
package pic_pkg;
  localparam int unsigned TRACKED = 4;
  localparam int unsigned STAGES  = TRACKED + 1;

  typedef enum int unsigned {
    PS_ID  = 0,
    PS_EX  = 1,
    PS_MEM = 2,
    PS_WB  = 3
  } stage_e;
endpackage

// File: rtl/pic_hazard_unit.sv
module pic_hazard_unit #(
  parameter int unsigned REG_W = 5
) (
  input  logic             id_vld,
  input  logic [REG_W-1:0] id_src_a,
  input  logic [REG_W-1:0] id_src_b,
  input  logic             ex_vld,
  input  logic [REG_W-1:0] ex_dst,
  input  logic             mem_vld,
  input  logic [REG_W-1:0] mem_dst,
  input  logic             mem_acc,
  output logic             raw_stall,
  output logic             port_stall
);
  localparam int unsigned NSRC  = 2;
  localparam int unsigned NPROD = 2;

  logic [NSRC-1:0][REG_W-1:0]  src;
  logic [NPROD-1:0]            prod_vld;
  logic [NPROD-1:0][REG_W-1:0] prod_dst;
  logic [NSRC*NPROD-1:0]       hit;

  assign src[0]      = id_src_a;
  assign src[1]      = id_src_b;
  assign prod_vld[0] = ex_vld;
  assign prod_vld[1] = mem_vld;
  assign prod_dst[0] = ex_dst;
  assign prod_dst[1] = mem_dst;

  // write-back is not compared: the register file writes before it is read
  for (genvar s = 0; s < NSRC; s++) begin : g_src
    for (genvar p = 0; p < NPROD; p++) begin : g_prod
      assign hit[s*NPROD+p] = id_vld && (src[s] != '0) && prod_vld[p]
                              && (prod_dst[p] == src[s]);
    end
  end

  assign raw_stall  = |hit;
  assign port_stall = mem_vld && mem_acc;
endmodule

// File: rtl/pic_stage_pipe.sv
module pic_stage_pipe
  import pic_pkg::*;
#(
  parameter int unsigned REG_W = 5
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push,
  input  logic                         push_mem,
  input  logic [REG_W-1:0]             push_dst,
  input  logic [REG_W-1:0]             push_src_a,
  input  logic [REG_W-1:0]             push_src_b,
  input  logic                         hold_id,
  output logic [TRACKED-1:0]           vld,
  output logic [TRACKED-1:0]           acc,
  output logic [TRACKED-1:0][REG_W-1:0] dst,
  output logic [REG_W-1:0]             id_src_a,
  output logic [REG_W-1:0]             id_src_b
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      vld      <= '0;
      acc      <= '0;
      dst      <= '0;
      id_src_a <= '0;
      id_src_b <= '0;
    end else begin
      if (!hold_id) begin
        vld[PS_ID] <= push;
        acc[PS_ID] <= push && push_mem;
        dst[PS_ID] <= push_dst;
        id_src_a   <= push_src_a;
        id_src_b   <= push_src_b;
      end
      vld[PS_EX] <= vld[PS_ID] && !hold_id;
      acc[PS_EX] <= acc[PS_ID] && !hold_id;
      dst[PS_EX] <= dst[PS_ID];
      for (int k = int'(PS_MEM); k < int'(TRACKED); k++) begin
        vld[k] <= vld[k-1];
        acc[k] <= acc[k-1];
        dst[k] <= dst[k-1];
      end
    end
  end

  AST_EX_GETS_BUBBLE: assert property (@(posedge clk) disable iff (!rst_n)
    hold_id |=> !vld[PS_EX]); // R4
  AST_ID_KEEPS_INSN: assert property (@(posedge clk) disable iff (!rst_n)
    hold_id |=> (vld[PS_ID] && $stable(id_src_a) && $stable(id_src_b)
                 && $stable(dst[PS_ID]))); // R4
  AST_SHIFT_TO_WB: assert property (@(posedge clk) disable iff (!rst_n)
    vld[PS_MEM] |=> vld[PS_WB]); // R2
endmodule

// File: rtl/pic_retire_ctr.sv
module pic_retire_ctr #(
  parameter int unsigned CNT_W = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             inc,
  output logic [CNT_W-1:0] cnt
);
  always_ff @(posedge clk) begin
    if (!rst_n)   cnt <= '0;
    else if (inc) cnt <= cnt + 1'b1;
  end

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    inc |=> (cnt == CNT_W'($past(cnt) + 1'b1))); // R7
  AST_COUNT_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !inc |=> $stable(cnt)); // R7
endmodule

// File: rtl/pipe_interlock.sv
module pipe_interlock
  import pic_pkg::*;
#(
  parameter int unsigned REG_W = 5,
  parameter int unsigned CNT_W = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               in_valid,
  output logic               in_ready,
  input  logic               in_mem,
  input  logic [REG_W-1:0]   in_dst,
  input  logic [REG_W-1:0]   in_src_a,
  input  logic [REG_W-1:0]   in_src_b,
  output logic               pc_hold,
  output logic               id_hold,
  output logic               id_nop,
  output logic               ex_nop,
  output logic [STAGES-1:0]  stage_busy,
  output logic               retire,
  output logic [CNT_W-1:0]   retire_count
);
  logic                          raw_stall, port_stall, push;
  logic [TRACKED-1:0]            vld, acc;
  logic [TRACKED-1:0][REG_W-1:0] dst;
  logic [REG_W-1:0]              id_src_a, id_src_b;

  pic_hazard_unit #(.REG_W(REG_W)) u_hazard (
    .id_vld    (vld[PS_ID]),
    .id_src_a  (id_src_a),
    .id_src_b  (id_src_b),
    .ex_vld    (vld[PS_EX]),
    .ex_dst    (dst[PS_EX]),
    .mem_vld   (vld[PS_MEM]),
    .mem_dst   (dst[PS_MEM]),
    .mem_acc   (acc[PS_MEM]),
    .raw_stall (raw_stall),
    .port_stall(port_stall)
  );

  // either stall freezes fetch; a dependency stall also freezes decode
  assign in_ready = !(raw_stall || port_stall);
  assign push     = in_valid && in_ready;
  assign pc_hold  = raw_stall || port_stall;
  assign id_hold  = raw_stall;
  assign ex_nop   = raw_stall;
  assign id_nop   = port_stall && !raw_stall;

  pic_stage_pipe #(.REG_W(REG_W)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_n),
    .push      (push),
    .push_mem  (in_mem),
    .push_dst  (in_dst),
    .push_src_a(in_src_a),
    .push_src_b(in_src_b),
    .hold_id   (raw_stall),
    .vld       (vld),
    .acc       (acc),
    .dst       (dst),
    .id_src_a  (id_src_a),
    .id_src_b  (id_src_b)
  );

  assign stage_busy = {vld, push};
  assign retire     = vld[PS_WB];

  pic_retire_ctr #(.CNT_W(CNT_W)) u_ctr (
    .clk  (clk),
    .rst_n(rst_n),
    .inc  (retire),
    .cnt  (retire_count)
  );

  AST_MEMPORT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (vld[PS_MEM] && acc[PS_MEM]) |-> (!in_ready && pc_hold)); // R3
  AST_ZERO_SOURCES_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    (id_src_a == '0 && id_src_b == '0) |-> !id_hold); // R5
  AST_BOTH_STALLS_KEEP_ID: assert property (@(posedge clk) disable iff (!rst_n)
    (id_hold && vld[PS_MEM] && acc[PS_MEM]) |-> (!id_nop && !in_ready)); // R6
  AST_ACCEPT_TO_DECODE: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> vld[PS_ID]); // R8
endmodule

// File: tb/pipe_interlock_test.sv
`timescale 1ns/1ps
module pipe_interlock_test;
  localparam int unsigned RW = 3;
  localparam int unsigned CW = 4;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0, in_mem = 1'b0;
  logic [RW-1:0] in_dst = '0, in_src_a = '0, in_src_b = '0;
  logic          in_ready, pc_hold, id_hold, id_nop, ex_nop, retire;
  logic [4:0]    stage_busy;
  logic [CW-1:0] retire_count;

  int total = 0, bad = 0;
  bit done = 1'b0;

  // bench model: index 0 decode, 1 execute, 2 memory, 3 write-back
  bit          mv[4];
  bit          mm[4];
  logic [RW-1:0] md[4];
  logic [RW-1:0] msa, msb;
  int          mcnt = 0;
  bit          last_acc, last_ret;

  always #4 clk = ~clk;

  pipe_interlock #(.REG_W(RW), .CNT_W(CW)) uut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .in_mem(in_mem), .in_dst(in_dst), .in_src_a(in_src_a), .in_src_b(in_src_b),
    .pc_hold(pc_hold), .id_hold(id_hold), .id_nop(id_nop), .ex_nop(ex_nop),
    .stage_busy(stage_busy), .retire(retire), .retire_count(retire_count)
  );

  task automatic chk(input int unsigned act, input int unsigned exp, input string tag);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit depends(input logic [RW-1:0] r);
    return (r != 0) && ((mv[1] && md[1] == r) || (mv[2] && md[2] == r));
  endfunction

  // compare the current cycle against the model, then advance the model
  task automatic tick();
    bit d, s, rdy, acc;
    #1;
    d   = mv[0] && (depends(msa) || depends(msb));
    s   = mv[2] && mm[2];
    rdy = !(d || s);
    acc = in_valid && rdy;
    chk(in_ready, rdy, "R8 in_ready");
    chk(pc_hold, d || s, "R3 pc_hold");
    chk({id_hold, ex_nop}, {d, d}, "R4 id_hold/ex_nop");
    chk(id_nop, s && !d, "R6 id_nop");
    chk(stage_busy, {mv[3], mv[2], mv[1], mv[0], acc}, "R9 stage_busy");
    chk(retire, mv[3], "R2 retire");
    chk(retire_count, mcnt, "R7 retire_count");
    last_ret = mv[3];
    last_acc = acc;
    if (mv[3]) mcnt = (mcnt + 1) % (1 << CW);
    mv[3] = mv[2]; mm[3] = mm[2]; md[3] = md[2];
    mv[2] = mv[1]; mm[2] = mm[1]; md[2] = md[1];
    mv[1] = mv[0] && !d; mm[1] = mm[0] && !d; md[1] = md[0];
    if (!d) begin
      mv[0] = acc; mm[0] = acc && in_mem; md[0] = in_dst;
      msa = in_src_a; msb = in_src_b;
    end
    @(negedge clk);
  endtask

  bit          q_mem[4];
  logic [RW-1:0] q_dst[4], q_sa[4], q_sb[4];

  task automatic set_q(input int i, input bit m, input int d, input int a, input int b);
    q_mem[i] = m; q_dst[i] = RW'(d); q_sa[i] = RW'(a); q_sb[i] = RW'(b);
  endtask

  // feed n queued descriptors; return step of the last retirement
  task automatic run_seq(input int n, output int last_step);
    int idx = 0, got = 0, step = 0;
    last_step = -1;
    while (got < n) begin
      in_valid = (idx < n);
      if (idx < n) begin
        in_mem = q_mem[idx]; in_dst = q_dst[idx];
        in_src_a = q_sa[idx]; in_src_b = q_sb[idx];
      end
      tick();
      if (last_acc) idx++;
      if (last_ret) begin got++; last_step = step; end
      step++;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    in_valid = 1'b0;
    for (int i = 0; i < n; i++) tick();
  endtask

  initial begin
    int ls;
    for (int i = 0; i < 4; i++) begin mv[i] = 0; mm[i] = 0; md[i] = '0; end
    msa = '0; msb = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    #1;
    // R1 reset state
    chk(stage_busy, 0, "R1 stage_busy");
    chk({pc_hold, id_hold, id_nop, ex_nop, retire}, 0, "R1 controls");
    chk(in_ready, 1, "R1 in_ready");
    chk(retire_count, 0, "R1 retire_count");
    @(negedge clk);

    // R2 four independent ALU instructions
    set_q(0, 0, 1, 0, 0); set_q(1, 0, 2, 0, 0); set_q(2, 0, 3, 0, 0); set_q(3, 0, 4, 0, 0);
    run_seq(4, ls); chk(ls, 7, "R2 fill plus one per cycle");
    idle(2);
    // R4 back-to-back dependency through r3
    set_q(0, 0, 3, 1, 2); set_q(1, 0, 4, 3, 0);
    run_seq(2, ls); chk(ls, 7, "R4 dependent pair waits two cycles");
    idle(2);
    // R3 load then three independent instructions
    set_q(0, 1, 4, 0, 0); set_q(1, 0, 1, 0, 0); set_q(2, 0, 2, 0, 0); set_q(3, 0, 3, 0, 0);
    run_seq(4, ls); chk(ls, 8, "R3 fetch delayed by memory access");
    idle(2);
    // R6 load followed by its consumer: both stalls overlap
    set_q(0, 1, 5, 0, 0); set_q(1, 0, 6, 0, 5);
    run_seq(2, ls); chk(ls, 7, "R6 overlap keeps consumer in decode");
    idle(2);
    // R5 register 0 as destination and sources
    set_q(0, 0, 0, 1, 1); set_q(1, 0, 2, 0, 0);
    run_seq(2, ls); chk(ls, 5, "R5 register 0 never stalls");
    idle(2);

    // constrained random with back-pressure: hold descriptor until taken
    void'($urandom(32'd20240611));
    for (int i = 0; i < 2000; i++) begin
      if (!(in_valid && !last_acc) || i == 0) begin
        in_valid = ($urandom % 10) < 8;
        in_mem   = ($urandom % 10) < 3;
        in_dst   = RW'($urandom);
        in_src_a = RW'($urandom);
        in_src_b = RW'($urandom);
      end
      tick();
    end
    idle(6);
    done = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      total++; bad++;
      $display("FAIL R2 watchdog actual=%0d expected=%0d", 200000, 0);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule